// File: doc/BRIEF.md
# SPI Master Serial Transfer Engine

This block is the bit-level core of an SPI master. It divides the system clock down to a serial clock, frames each byte with an active-low chip select, and shifts data out on MOSI while it captures data from MISO. Bytes are taken from an upstream transmit queue through a valid/pop handshake, and each received byte is presented with a one-cycle strobe. Data is MSB first and uses SPI mode 0: the clock idles low, the receiver samples on the rising edge and MOSI changes on the falling edge.

A byte transfer starts when transmit data is queued. It can also start when a receive-queue read strobe arrives while the engine runs in read-initiated mode with receive flushing active. A transfer that starts with no queued data shifts out a fill byte. The fill byte is either 0x00 or a repeat of the last byte sent. Chip select is either released after every byte, or held across a run of queued bytes. An internal loopback feeds MOSI back into the receiver. An optional capture path clocks the receive shift register directly from the serial clock, which compensates for pad delay at high rates.

Top module: `spi_shift_engine`

## Requirements
- R1: After reset, cs_n is 1, sclk is 0, mosi is 0, miso_oe is 0 and rx_strobe is 0.
- R2: While a byte is shifting, successive rising edges of sclk are 2*(cfg_div+1) system clocks apart, and sclk is 0 whenever cs_n is 1.
- R3: Each byte accepted from the transmit queue (tx_valid and tx_pop both 1 in a cycle) appears on mosi MSB first, stable at every rising sclk edge.
- R4: The eight values of the serial input at the rising sclk edges form rx_data MSB first, and rx_data is presented with a single-cycle rx_strobe after the eighth bit.
- R5: With cfg_cont = 0, cs_n returns to 1 after every byte, and stays 1 for at least 2*(cfg_div+1) and at most 2*(cfg_div+1)+2 system clocks before the next byte.
- R6: With cfg_cont = 1, cs_n stays 0 across consecutive bytes while tx_valid is 1 at each byte end, and returns to 1 once no data is queued.
- R7: A transfer started with no queued data while cfg_zero_fill = 1 shifts out 0x00.
- R8: A transfer started with no queued data while cfg_zero_fill = 0 shifts out the last byte previously shifted out.
- R9: With cfg_loopback = 1, the received byte equals the byte shifted out on mosi, and miso has no effect.
- R10: With cfg_hf_capture = 1, the received byte is captured on the serial clock edge and equals the MISO byte, as in the system-clock capture path.
- R11: miso_oe equals cfg_miso_oe delayed by one system clock, so it is 0 (pin released) whenever the configuration bit has been clear.
- R12: A one-cycle rx_read pulse while idle with no queued data starts a transfer only when cfg_rx_flush = 1 and cfg_tx_start_mode = 0 (0 means read-initiated). Otherwise cs_n stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_div | input | 6 | Serial clock divide factor; the half period is cfg_div+1 clocks |
| cfg_cont | input | 1 | Hold chip select across queued bytes |
| cfg_zero_fill | input | 1 | Fill byte on underrun: 1 selects 0x00, 0 repeats the last byte |
| cfg_loopback | input | 1 | Take receive input from MOSI instead of MISO |
| cfg_hf_capture | input | 1 | Capture receive bits on the serial clock edge |
| cfg_miso_oe | input | 1 | MISO driver enable request |
| cfg_rx_flush | input | 1 | Receive flush active |
| cfg_tx_start_mode | input | 1 | 0 lets a receive read start a transfer; 1 starts transfers only from transmit data |
| rx_read | input | 1 | Receive-queue read strobe |
| tx_valid | input | 1 | Transmit queue holds a byte |
| tx_data | input | 8 | Head byte of the transmit queue |
| tx_pop | output | 1 | Head byte is taken this cycle |
| miso | input | 1 | Serial data from the slave |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the slave |
| cs_n | output | 1 | Active-low chip select |
| miso_oe | output | 1 | MISO output driver enable |
| rx_data | output | 8 | Last received byte |
| rx_strobe | output | 1 | One-cycle pulse when rx_data is updated |

## Verification
Queued bursts are sent at the fastest divider with framing per byte, and at a slower divider with chip select held. This separates the stall between bytes from continuous framing and shows that the edge spacing scales with the divider. Read-initiated starts with an empty queue are run with each fill policy. Running the repeat policy first, after a nonzero byte, keeps a repeat that wrongly sends zeros from passing. Loopback is driven with an all-ones MISO pattern that differs from the MOSI byte, so the receive source is visible. The serial-clock capture path gets its own byte pattern. Read strobes under the two blocked mode combinations must leave chip select untouched.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_STALL = 2'd2
  } eng_state_t;
endpackage

// File: rtl/spi_sclk_gen.sv
module spi_sclk_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt_q <= '0;
    end else if (cnt_q == div) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign tick = run && (cnt_q == div);

  // R2: every half-period tick restarts the count
  a_r2_tick_restart: assert property (@(posedge clk) disable iff (rst)
    tick |=> (cnt_q == '0));
endmodule

// File: rtl/spi_tx_source.sv
module spi_tx_source #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] sent_byte,
  input  logic              zero_fill,
  output logic [DATA_W-1:0] fill_byte
);
  logic [DATA_W-1:0] last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= '0;
    end else if (load) begin
      last_q <= sent_byte;
    end
  end

  assign fill_byte = zero_fill ? '0 : last_q;

  // R8: the remembered byte only moves when a byte is loaded
  a_r8_last_stable: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(last_q));
endmodule

// File: rtl/spi_rx_capture.sv
module spi_rx_capture #(
  parameter int DATA_W = 8,
  parameter bit HF_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_in,
  input  logic              sample,
  input  logic              done,
  input  logic              sclk,
  input  logic              hf_sel,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_strobe
);
  logic [DATA_W-1:0] sys_sh_q;
  logic [DATA_W-1:0] hf_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sys_sh_q <= '0;
    end else if (sample) begin
      sys_sh_q <= {sys_sh_q[DATA_W-2:0], rx_in};
    end
  end

  generate
    if (HF_EN) begin : g_hf
      logic [DATA_W-1:0] hf_sh_q;
      always_ff @(posedge sclk) begin
        hf_sh_q <= {hf_sh_q[DATA_W-2:0], rx_in};
      end
      assign hf_sh = hf_sh_q;
    end else begin : g_no_hf
      assign hf_sh = sys_sh_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data   <= '0;
      rx_strobe <= 1'b0;
    end else begin
      rx_strobe <= done;
      if (done) begin
        rx_data <= hf_sel ? hf_sh : sys_sh_q;
      end
    end
  end

  // R4: the received-byte strobe lasts one cycle
  a_r4_strobe_pulse: assert property (@(posedge clk) disable iff (rst)
    rx_strobe |=> !rx_strobe);
  // R4: rx_data holds between strobes
  a_r4_data_hold: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(rx_data));
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine #(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 6,
  parameter bit HF_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic              cfg_cont,
  input  logic              cfg_zero_fill,
  input  logic              cfg_loopback,
  input  logic              cfg_hf_capture,
  input  logic              cfg_miso_oe,
  input  logic              cfg_rx_flush,
  input  logic              cfg_tx_start_mode,
  input  logic              rx_read,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  output logic              tx_pop,
  input  logic              miso,
  output logic              sclk,
  output logic              mosi,
  output logic              cs_n,
  output logic              miso_oe,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_strobe
);
  import spi_eng_pkg::*;

  localparam int BIT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(DATA_W - 1);

  eng_state_t        state_q;
  logic              sclk_q;
  logic              cs_n_q;
  logic              oe_q;
  logic              stall_half_q;
  logic [DATA_W-1:0] sh_q;
  logic [BIT_W-1:0]  bit_q;

  logic              tick;
  logic              rise_ev;
  logic              fall_ev;
  logic              last_bit;
  logic              byte_end;
  logic              read_start;
  logic              start_idle;
  logic              chain;
  logic              load;
  logic [DATA_W-1:0] fill_byte;
  logic [DATA_W-1:0] load_byte;
  logic              rx_in;

  spi_sclk_gen #(.DIV_W(DIV_W)) i_sclk_gen (
    .clk  (clk),
    .rst  (rst),
    .run  (state_q != ST_IDLE),
    .div  (cfg_div),
    .tick (tick)
  );

  assign rise_ev    = (state_q == ST_SHIFT) && tick && !sclk_q;
  assign fall_ev    = (state_q == ST_SHIFT) && tick && sclk_q;
  assign last_bit   = (bit_q == LAST_BIT);
  assign byte_end   = fall_ev && last_bit;
  assign read_start = cfg_rx_flush && !cfg_tx_start_mode && rx_read;
  assign start_idle = (state_q == ST_IDLE) && (tx_valid || read_start);
  assign chain      = byte_end && cfg_cont && tx_valid;
  assign load       = start_idle || chain;
  assign tx_pop     = load && tx_valid;
  assign load_byte  = tx_valid ? tx_data : fill_byte;

  spi_tx_source #(.DATA_W(DATA_W)) i_tx_source (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .sent_byte (load_byte),
    .zero_fill (cfg_zero_fill),
    .fill_byte (fill_byte)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      sclk_q       <= 1'b0;
      cs_n_q       <= 1'b1;
      oe_q         <= 1'b0;
      stall_half_q <= 1'b0;
      sh_q         <= '0;
      bit_q        <= '0;
    end else begin
      oe_q <= cfg_miso_oe;
      case (state_q)
        ST_IDLE: begin
          if (load) begin
            state_q <= ST_SHIFT;
            cs_n_q  <= 1'b0;
            sh_q    <= load_byte;
            bit_q   <= '0;
          end
        end
        ST_SHIFT: begin
          if (rise_ev) begin
            sclk_q <= 1'b1;
          end
          if (fall_ev) begin
            sclk_q <= 1'b0;
            if (!last_bit) begin
              sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
              bit_q <= bit_q + 1'b1;
            end else if (chain) begin
              sh_q  <= load_byte;
              bit_q <= '0;
            end else begin
              cs_n_q       <= 1'b1;
              state_q      <= ST_STALL;
              stall_half_q <= 1'b0;
            end
          end
        end
        ST_STALL: begin
          if (tick) begin
            if (stall_half_q) begin
              state_q <= ST_IDLE;
            end else begin
              stall_half_q <= 1'b1;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign rx_in = cfg_loopback ? sh_q[DATA_W-1] : miso;

  spi_rx_capture #(.DATA_W(DATA_W), .HF_EN(HF_EN)) i_rx_capture (
    .clk       (clk),
    .rst       (rst),
    .rx_in     (rx_in),
    .sample    (rise_ev),
    .done      (byte_end),
    .sclk      (sclk_q),
    .hf_sel    (cfg_hf_capture),
    .rx_data   (rx_data),
    .rx_strobe (rx_strobe)
  );

  assign sclk    = sclk_q;
  assign mosi    = sh_q[DATA_W-1];
  assign cs_n    = cs_n_q;
  assign miso_oe = oe_q;

  // R2: the serial clock rests low while the slave is deselected
  a_r2_idle_low: assert property (@(posedge clk) disable iff (rst)
    cs_n_q |-> !sclk_q);
  // R6: a chained byte keeps chip select asserted
  a_r6_cs_held: assert property (@(posedge clk) disable iff (rst)
    chain |=> !cs_n_q);
  // R11: released driver follows a clear enable bit
  a_r11_oe_follow: assert property (@(posedge clk) disable iff (rst)
    !cfg_miso_oe |=> !miso_oe);
  // R12: nothing starts without queued data or a permitted read
  a_r12_no_start: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_IDLE) && !tx_valid && !read_start) |=> cs_n_q);
  // R3: a byte is only taken while the queue offers one
  a_r3_pop_valid: assert property (@(posedge clk) disable iff (rst)
    tx_pop |-> tx_valid);
endmodule

// File: tb/test_spi_shift_engine.sv
module test_spi_shift_engine;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] cfg_div = '0;
  logic       cfg_cont = 1'b0;
  logic       cfg_zero_fill = 1'b0;
  logic       cfg_loopback = 1'b0;
  logic       cfg_hf_capture = 1'b0;
  logic       cfg_miso_oe = 1'b0;
  logic       cfg_rx_flush = 1'b0;
  logic       cfg_tx_start_mode = 1'b0;
  logic       rx_read = 1'b0;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = '0;
  logic       tx_pop;
  logic       miso = 1'b0;
  logic       sclk, mosi, cs_n, miso_oe, rx_strobe;
  logic [7:0] rx_data;

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  spi_shift_engine i_spi_shift_engine (
    .clk(clk), .rst(rst), .cfg_div(cfg_div), .cfg_cont(cfg_cont),
    .cfg_zero_fill(cfg_zero_fill), .cfg_loopback(cfg_loopback),
    .cfg_hf_capture(cfg_hf_capture), .cfg_miso_oe(cfg_miso_oe),
    .cfg_rx_flush(cfg_rx_flush), .cfg_tx_start_mode(cfg_tx_start_mode),
    .rx_read(rx_read), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_pop(tx_pop), .miso(miso), .sclk(sclk), .mosi(mosi), .cs_n(cs_n),
    .miso_oe(miso_oe), .rx_data(rx_data), .rx_strobe(rx_strobe)
  );

  always #5 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // transmit queue model
  logic [7:0] txf[$];
  logic pop_seen = 1'b0;
  always @(posedge clk) pop_seen <= tx_pop;
  always @(negedge clk) begin
    if (pop_seen && txf.size() > 0) void'(txf.pop_front());
    tx_valid = (txf.size() > 0);
    tx_data  = (txf.size() > 0) ? txf[0] : 8'h00;
  end

  // scoreboard queues
  logic [7:0] exp_mosi[$];
  string      tag_mosi[$];
  logic [7:0] exp_rx[$];
  string      tag_rx[$];

  // slave model: presents bytes MSB first, changing after falling edges
  logic [7:0] sq[$];
  logic [7:0] cur = '0;
  bit have_cur = 1'b0;
  int sbit = 0;
  always @(negedge cs_n) begin
    if (!have_cur && sq.size() > 0) begin
      cur = sq.pop_front();
      have_cur = 1'b1;
    end
    sbit = 0;
    miso = cur[7];
  end
  always @(negedge sclk) begin
    sbit++;
    if (sbit == 8) begin
      sbit = 0;
      if (sq.size() > 0) cur = sq.pop_front();
      else have_cur = 1'b0;
      miso = cur[7];
    end else begin
      miso = cur[7 - sbit];
    end
  end

  // cycle counter and edge timing
  int cyc = 0;
  always @(posedge clk) cyc++;

  bit check_period = 1'b0;
  bit check_gap = 1'b0;
  int period_checks = 0;
  int last_rise = 0;
  int mbits = 0;
  logic [7:0] mbyte = '0;
  always @(posedge sclk) begin
    if (check_period && mbits == 1 && period_checks < 6) begin
      period_checks++;
      chk("R2 sclk period", cyc - last_rise, 2 * (int'(cfg_div) + 1));
    end
    last_rise = cyc;
    mbyte = {mbyte[6:0], mosi};
    mbits++;
    if (mbits == 8) begin
      mbits = 0;
      if (exp_mosi.size() == 0) chk("R3 unexpected mosi byte", mbyte, 0);
      else chk(tag_mosi.pop_front(), mbyte, exp_mosi.pop_front());
    end
  end

  int cs_rises = 0;
  int cs_falls = 0;
  int rise_cyc = 0;
  always @(posedge cs_n) if (!rst) begin cs_rises++; rise_cyc = cyc; end
  always @(negedge cs_n) begin
    cs_falls++;
    if (check_gap && cs_rises > 0) begin
      int h2;
      h2 = 2 * (int'(cfg_div) + 1);
      chk("R5 cs gap in range",
          ((cyc - rise_cyc) >= h2 && (cyc - rise_cyc) <= h2 + 2) ? 1 : 0, 1);
    end
  end

  always @(negedge clk) begin
    if (!rst && rx_strobe) begin
      if (exp_rx.size() == 0) chk("R4 unexpected rx strobe", rx_data, 0);
      else chk(tag_rx.pop_front(), rx_data, exp_rx.pop_front());
    end
  end

  // driver
  task automatic push_item(input logic [7:0] m, input logic [7:0] s,
                           input logic [7:0] r, input string tg);
    exp_mosi.push_back(m); tag_mosi.push_back({tg, " mosi"});
    exp_rx.push_back(r);   tag_rx.push_back({tg, " rx"});
    sq.push_back(s);
  endtask

  task automatic queue_byte(input logic [7:0] m, input logic [7:0] s,
                            input string tg);
    push_item(m, s, cfg_loopback ? m : s, tg);
    txf.push_back(m);
  endtask

  task automatic pulse_read();
    @(posedge clk); #1 rx_read = 1'b1;
    @(posedge clk); #1 rx_read = 1'b0;
  endtask

  task automatic wait_done();
    @(negedge clk);
    while (exp_mosi.size() > 0 || exp_rx.size() > 0 || txf.size() > 0 || !cs_n)
      @(negedge clk);
    repeat (4 * (int'(cfg_div) + 1) + 6) @(negedge clk);
    @(posedge clk); #1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    vectors++;
    miscompares++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int f0, r0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    // R1 reset values
    chk("R1 cs_n", cs_n, 1);
    chk("R1 sclk", sclk, 0);
    chk("R1 mosi", mosi, 0);
    chk("R1 miso_oe", miso_oe, 0);
    chk("R1 rx_strobe", rx_strobe, 0);
    @(posedge clk); #1 rst = 1'b0;
    repeat (2) @(posedge clk); #1;

    // R3 R4 R5: framing per byte at the fastest divider
    cfg_div = 6'd0; check_period = 1'b1; check_gap = 1'b1;
    f0 = cs_falls;
    queue_byte(8'hA5, 8'h5A, "R3 R4 byte0");
    queue_byte(8'h3C, 8'hC3, "R3 R4 byte1");
    queue_byte(8'hF0, 8'h0F, "R3 R4 byte2");
    wait_done();
    chk("R5 one select per byte", cs_falls - f0, 3);
    check_gap = 1'b0;

    // R6: held chip select at a slower divider
    cfg_div = 6'd3; cfg_cont = 1'b1; period_checks = 0;
    f0 = cs_falls; r0 = cs_rises;
    queue_byte(8'h81, 8'h12, "R6 byte0");
    queue_byte(8'h7E, 8'h34, "R6 byte1");
    queue_byte(8'h55, 8'h56, "R6 byte2");
    wait_done();
    chk("R6 single select", cs_falls - f0, 1);
    chk("R6 single release", cs_rises - r0, 1);
    cfg_cont = 1'b0; check_period = 1'b0;

    // R8 then R7: read-initiated underrun starts
    cfg_div = 6'd1; cfg_rx_flush = 1'b1; cfg_tx_start_mode = 1'b0;
    cfg_zero_fill = 1'b0;
    push_item(8'h55, 8'h99, 8'h99, "R8 repeat last");
    pulse_read();
    wait_done();
    cfg_zero_fill = 1'b1;
    push_item(8'h00, 8'h66, 8'h66, "R7 zero fill");
    pulse_read();
    wait_done();
    cfg_zero_fill = 1'b0;

    // R12: blocked read-initiated starts
    f0 = cs_falls;
    cfg_tx_start_mode = 1'b1;
    pulse_read();
    repeat (20) @(posedge clk); #1;
    chk("R12 blocked by start mode", cs_falls - f0, 0);
    cfg_tx_start_mode = 1'b0; cfg_rx_flush = 1'b0;
    pulse_read();
    repeat (20) @(posedge clk); #1;
    chk("R12 blocked without flush", cs_falls - f0, 0);
    @(negedge clk);
    chk("R12 cs_n idle", cs_n, 1);

    // R9: loopback ignores miso
    cfg_loopback = 1'b1;
    queue_byte(8'hC9, 8'hFF, "R9 loopback");
    wait_done();
    cfg_loopback = 1'b0;

    // R10: serial-clock capture
    cfg_div = 6'd2; cfg_hf_capture = 1'b1;
    queue_byte(8'h6B, 8'h94, "R10 hf capture");
    wait_done();
    cfg_hf_capture = 1'b0;

    // R11: output enable follows the configuration bit
    cfg_miso_oe = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R11 oe set", miso_oe, 1);
    @(posedge clk); #1 cfg_miso_oe = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R11 oe clear", miso_oe, 0);

    chk("R3 mosi queue drained", exp_mosi.size(), 0);
    chk("R4 rx queue drained", exp_rx.size(), 0);
    finish_run();
  end
endmodule